// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Receiver with Address Filter

This block receives asynchronous serial frames from a single RX line. It uses a 16x oversampling tick that a baud generator outside the block supplies. A frame is a low start bit, then eight data bits sent least significant bit first, then an optional ninth bit, then a high stop bit.

Received frames go into a two-entry buffer. The host reads the buffer through a data port that shows the oldest entry; that entry's ninth bit and framing-error tag appear beside it. In nine-bit mode an address filter can discard every frame whose ninth bit is 0. A node on a multidrop bus uses this to wake only for address frames. Overrun is a sticky flag, and only turning the receiver off clears it.

A port-enable input holds all receive logic in reset. A separate receiver-enable input starts and stops reception without flushing frames already buffered.

Top module: `mp_uart_rx`

## Requirements
- R1: While `portEn` is 0, the buffer is empty, `dataReady`, `frmErr` and `ovrErr` are 0, and frames on `rxLine` are not received. Raising `portEn` again leaves the buffer empty.
- R2: With `wide9`=0, a frame of start bit, eight data bits (LSB first) and stop bit is stored. `dataReady` rises, `rdData` holds the byte, and `rdBit9` is 0.
- R3: With `wide9`=1 and `addrFilt`=0, the bit after the eighth data bit is captured into `rdBit9`. Frames are accepted whether that bit is 0 or 1, and no parity is computed.
- R4: With `wide9`=1 and `addrFilt`=1, a frame whose ninth bit is 0 is discarded. A frame whose ninth bit is 1 is stored and raises `dataReady`.
- R5: With `wide9`=0, `addrFilt` has no effect, and every frame is stored.
- R6: While `rxEn` is 0, frames on `rxLine` are not received.
- R7: A frame whose stop bit samples low is stored with a framing tag. `frmErr` is 1 while that entry is at the head. After the host reads it, `frmErr` follows the next entry, so a following good frame shows 0.
- R8: When a frame is accepted while both buffer entries are full, `ovrErr` is set, the new frame is lost, and the held entries are kept in order.
- R9: While `ovrErr` is 1, no frame is loaded, even after reads free space. `ovrErr` stays 1 until `rxEn` goes to 0, and it then clears.
- R10: A low pulse on `rxLine` that is high again at the middle of the start bit is rejected. No frame results, and the next real frame is received correctly.
- R11: The buffer holds two entries and returns them oldest first. A pulse on `rdStrobe` removes the head entry, and `dataReady` is 1 exactly while the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; 0 holds the receiver in reset |
| rxEn | input | 1 | Receiver enable; 0 stops reception and clears overrun |
| wide9 | input | 1 | 1 selects nine-bit frames, 0 eight-bit frames |
| addrFilt | input | 1 | Address filter, effective in nine-bit mode only |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial input, idle high |
| rdStrobe | input | 1 | Reads (removes) the head entry |
| rdData | output | 8 | Data byte of the head entry, 0 when empty |
| rdBit9 | output | 1 | Ninth bit of the head entry |
| frmErr | output | 1 | Framing tag of the head entry |
| ovrErr | output | 1 | Sticky overrun flag |
| dataReady | output | 1 | Buffer not empty (receive interrupt) |

## Verification
The bench fills the buffer and sends a third frame. It then reads space free and sends a fourth frame to confirm that overrun blocks loading. A design that cleared overrun on a read, or loaded frames during overrun, would show a new head byte or a cleared flag. Address-filtered frames are sent with the ninth bit at 0 and at 1, and once with eight-bit mode selected, where the filter must not act. A broken filter either drops eight-bit frames or passes ninth-bit-0 frames. A bad-stop frame followed by a good one checks that the framing flag moves with the head entry. A short low glitch checks that the mid-start test rejects it rather than assembling a false byte.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic sampleBit;
    logic frameDone;
    logic stopOk;
  } rxStrobe_t;
endpackage

// File: rtl/mp_uart_rx_ctrl.sv
module mp_uart_rx_ctrl
  import mp_uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      wide9,
  input  logic      tick,
  input  logic      lineIn,
  output rxStrobe_t strb
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] lastBit;

  assign lastBit = wide9 ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!runEn) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (!lineIn) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
        ST_START: if (tickCnt == MID) begin
          tickCnt <= '0;
          bitIdx  <= '0;
          state   <= lineIn ? ST_IDLE : ST_DATA;
        end else tickCnt <= tickCnt + 1'b1;
        ST_DATA: if (tickCnt == LAST) begin
          tickCnt <= '0;
          bitIdx  <= bitIdx + 1'b1;
          if (bitIdx == lastBit) state <= ST_STOP;
        end else tickCnt <= tickCnt + 1'b1;
        ST_STOP: if (tickCnt == LAST) begin
          tickCnt <= '0;
          state   <= ST_IDLE;
        end else tickCnt <= tickCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.sampleBit = runEn && tick && (state == ST_DATA) && (tickCnt == LAST);
    strb.frameDone = runEn && tick && (state == ST_STOP) && (tickCnt == LAST);
    strb.stopOk    = lineIn;
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (state == ST_IDLE)) else $error("receiver not idle while off"); // R6
  AST_DONE_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> (state == ST_IDLE)) else $error("frame end did not return to idle"); // R2
endmodule

// File: rtl/mp_uart_rx_dp.sv
module mp_uart_rx_dp
  import mp_uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              rxEn,
  input  logic              wide9,
  input  logic              addrFilt,
  input  logic              lineIn,
  input  rxStrobe_t         strb,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit9,
  output logic              frmErr,
  output logic              ovrErr,
  output logic              dataReady
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W:0]   shReg;
  logic [DATA_W-1:0] memData [DEPTH];
  logic              memB9   [DEPTH];
  logic              memFe   [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  logic [DATA_W-1:0] newData;
  logic              newB9, accept, full, push, pop;

  assign newData = wide9 ? shReg[DATA_W-1:0] : shReg[DATA_W:1];
  assign newB9   = wide9 & shReg[DATA_W];
  assign accept  = strb.frameDone & ~(wide9 & addrFilt & ~newB9);
  assign full    = (count == CNT_FULL);
  assign push    = accept & ~full & ~ovrErr;
  assign pop     = rdStrobe & (count != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.sampleBit) shReg <= {lineIn, shReg[DATA_W:1]};
  end

  always_ff @(posedge clk) begin
    if (push) begin
      memData[wrPtr] <= newData;
      memB9[wrPtr]   <= newB9;
      memFe[wrPtr]   <= ~strb.stopOk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      ovrErr <= 1'b0;
    end else if (!portEn) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      ovrErr <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (!rxEn) ovrErr <= 1'b0;
      else if (accept && full) ovrErr <= 1'b1;
    end
  end

  assign dataReady = (count != '0);
  assign rdData    = dataReady ? memData[rdPtr] : '0;
  assign rdBit9    = dataReady & memB9[rdPtr];
  assign frmErr    = dataReady & memFe[rdPtr];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL) else $error("buffer count beyond depth"); // R11
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovrErr && portEn && rxEn) |=> ovrErr) else $error("overrun cleared while enabled"); // R9
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !ovrErr) else $error("overrun kept while receiver off"); // R9
  AST_NO_LOAD_OVR: assert property (@(posedge clk) disable iff (!rstN)
    ovrErr |=> (count <= $past(count))) else $error("frame loaded during overrun"); // R9
  AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && wide9 && addrFilt && !shReg[DATA_W]) |=> (count <= $past(count)))
    else $error("data frame passed address filter"); // R4
  AST_PORT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!dataReady && !ovrErr)) else $error("state kept while port off"); // R1
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              rxEn,
  input  logic              wide9,
  input  logic              addrFilt,
  input  logic              tick16,
  input  logic              rxLine,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit9,
  output logic              frmErr,
  output logic              ovrErr,
  output logic              dataReady
);
  logic [1:0] syncQ;
  logic       lineIn;
  rxStrobe_t  strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineIn = syncQ[1];

  mp_uart_rx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (portEn & rxEn),
    .wide9  (wide9),
    .tick   (tick16),
    .lineIn (lineIn),
    .strb   (strb)
  );

  mp_uart_rx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .portEn    (portEn),
    .rxEn      (rxEn),
    .wide9     (wide9),
    .addrFilt  (addrFilt),
    .lineIn    (lineIn),
    .strb      (strb),
    .rdStrobe  (rdStrobe),
    .rdData    (rdData),
    .rdBit9    (rdBit9),
    .frmErr    (frmErr),
    .ovrErr    (ovrErr),
    .dataReady (dataReady)
  );
endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b0, rxEn = 1'b0, wide9 = 1'b0, addrFilt = 1'b0;
  logic       rxLine = 1'b1, rdStrobe = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       tick16;
  logic [7:0] rdData;
  logic       rdBit9, frmErr, ovrErr, dataReady;
  int         nChk = 0, nBad = 0;
  bit         done = 1'b0;

  localparam int BIT_CLK = 64;

  always #10 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd0);

  mp_uart_rx dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .rxEn(rxEn), .wide9(wide9),
    .addrFilt(addrFilt), .tick16(tick16), .rxLine(rxLine), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdBit9(rdBit9), .frmErr(frmErr), .ovrErr(ovrErr),
    .dataReady(dataReady)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic b9, input bit nine, input logic stopV);
    @(negedge clk) rxLine = 1'b0;
    repeat (BIT_CLK - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rxLine = d[i];
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    if (nine) begin
      @(negedge clk) rxLine = b9;
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    @(negedge clk) rxLine = stopV;
    repeat (BIT_CLK - 1) @(negedge clk);
    @(negedge clk) rxLine = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic readHead();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic tReset();
    check("R1", "ready after reset", dataReady, 0);
    check("R1", "ovr after reset", ovrErr, 0);
    check("R1", "ferr after reset", frmErr, 0);
  endtask

  task automatic tBasic8();
    wide9 = 0; addrFilt = 0;
    sendFrame(8'hA5, 1'b0, 0, 1'b1);
    check("R2", "ready", dataReady, 1);
    check("R2", "data", rdData, 8'hA5);
    check("R2", "bit9", rdBit9, 0);
    readHead();
    check("R11", "empty after read", dataReady, 0);
  endtask

  task automatic tOrder();
    sendFrame(8'h11, 1'b0, 0, 1'b1);
    sendFrame(8'h22, 1'b0, 0, 1'b1);
    check("R11", "head first", rdData, 8'h11);
    readHead();
    check("R11", "head second", rdData, 8'h22);
    readHead();
    check("R11", "drained", dataReady, 0);
  endtask

  task automatic tNine();
    wide9 = 1; addrFilt = 0;
    sendFrame(8'h5A, 1'b1, 1, 1'b1);
    check("R3", "data b9=1", rdData, 8'h5A);
    check("R3", "bit9 set", rdBit9, 1);
    readHead();
    sendFrame(8'h33, 1'b0, 1, 1'b1);
    check("R3", "b9=0 accepted", dataReady, 1);
    check("R3", "data b9=0", rdData, 8'h33);
    check("R3", "bit9 clear", rdBit9, 0);
    readHead();
  endtask

  task automatic tAddr();
    wide9 = 1; addrFilt = 1;
    sendFrame(8'h44, 1'b0, 1, 1'b1);
    check("R4", "data frame dropped", dataReady, 0);
    sendFrame(8'h81, 1'b1, 1, 1'b1);
    check("R4", "addr frame ready", dataReady, 1);
    check("R4", "addr data", rdData, 8'h81);
    check("R4", "addr bit9", rdBit9, 1);
    readHead();
  endtask

  task automatic tAddr8();
    wide9 = 0; addrFilt = 1;
    sendFrame(8'h7E, 1'b0, 0, 1'b1);
    check("R5", "8-bit frame kept", dataReady, 1);
    check("R5", "8-bit data", rdData, 8'h7E);
    readHead();
    addrFilt = 0;
  endtask

  task automatic tRxOff();
    rxEn = 0;
    sendFrame(8'h99, 1'b0, 0, 1'b1);
    check("R6", "no rx while off", dataReady, 0);
    rxEn = 1;
  endtask

  task automatic tFrame();
    sendFrame(8'h3C, 1'b0, 0, 1'b0);
    check("R7", "bad stop stored", dataReady, 1);
    check("R7", "bad stop data", rdData, 8'h3C);
    check("R7", "ferr set", frmErr, 1);
    sendFrame(8'h5D, 1'b0, 0, 1'b1);
    check("R7", "ferr held before read", frmErr, 1);
    readHead();
    check("R7", "next head data", rdData, 8'h5D);
    check("R7", "ferr cleared", frmErr, 0);
    readHead();
  endtask

  task automatic tGlitch();
    @(negedge clk) rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    check("R10", "glitch ignored", dataReady, 0);
    sendFrame(8'h6B, 1'b0, 0, 1'b1);
    check("R10", "frame after glitch", rdData, 8'h6B);
    readHead();
  endtask

  task automatic tOverrun();
    sendFrame(8'h01, 1'b0, 0, 1'b1);
    sendFrame(8'h02, 1'b0, 0, 1'b1);
    check("R8", "no ovr at full", ovrErr, 0);
    sendFrame(8'h03, 1'b0, 0, 1'b1);
    check("R8", "ovr set", ovrErr, 1);
    check("R8", "head kept", rdData, 8'h01);
    readHead();
    check("R8", "second kept", rdData, 8'h02);
    readHead();
    check("R8", "third lost", dataReady, 0);
    sendFrame(8'h04, 1'b0, 0, 1'b1);
    check("R9", "no load in ovr", dataReady, 0);
    check("R9", "ovr sticky", ovrErr, 1);
    @(negedge clk) rxEn = 0;
    @(negedge clk) rxEn = 1;
    @(negedge clk);
    check("R9", "ovr cleared by rxEn", ovrErr, 0);
    sendFrame(8'h05, 1'b0, 0, 1'b1);
    check("R9", "rx resumes", rdData, 8'h05);
    readHead();
  endtask

  task automatic tPortOff();
    sendFrame(8'h77, 1'b0, 0, 1'b1);
    check("R1", "loaded before off", dataReady, 1);
    @(negedge clk) portEn = 0;
    @(negedge clk);
    check("R1", "flushed when off", dataReady, 0);
    sendFrame(8'h78, 1'b0, 0, 1'b1);
    check("R1", "no rx when off", dataReady, 0);
    @(negedge clk) portEn = 1;
    @(negedge clk);
    check("R1", "empty on re-enable", dataReady, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    portEn = 1; rxEn = 1;
    repeat (BIT_CLK) @(negedge clk);
    tBasic8();
    tOrder();
    tNine();
    tAddr();
    tAddr8();
    tRxOff();
    tFrame();
    tGlitch();
    tOverrun();
    tPortOff();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule